// File: doc/BRIEF.md
# Internal Fault and Lockstep Mismatch Reporter

This block drives a single error output and a sticky halt request for a core. It watches two sources of fault. The first is a bundle of parity-error strobes coming from the core's storage arrays. Any strobe starts a one-clock error pulse, and after that pulse the block holds a halt request. The halt request stays set until reset, or until a synchronous warm-initialization input clears it.

The second source is a lockstep comparator. When the device is strapped as the checking partner of a master, it compares the values it computed itself with the values observed on the shared pins, which the master drives. A compare is made only in cycles where a valid strobe marks those values as meaningful. A difference raises the error output two clocks after the cycle in which it was found. When the device is not strapped as a checker, differences are ignored.

The error output is the OR of the parity pulse and the delayed mismatch report. The parity path is a small state machine:
- `ST_RUN` goes to `ST_PULSE` when any strobe is high.
- `ST_PULSE` always goes to `ST_HALT`.
- `ST_HALT` holds.
- Warm initialization returns every state to `ST_RUN`.

The mismatch path is a flushable two-stage delay line.

Top module: `fault_reporter`

## Requirements
- R1: While and directly after reset, `err_out` and `halt_req` are 0.
- R2: If any bit of `par_err` is 1 in cycle c while the parity machine is in `ST_RUN` and `warm_init` is 0, then `err_out` is 1 in cycle c+1 and the parity contribution is 0 in cycle c+2. A strobe held high for several cycles still gives only one pulse.
- R3: `halt_req` becomes 1 in cycle c+2 after that strobe, which is the cycle after the pulse.
- R4: `halt_req` stays 1 until reset or until `warm_init` is 1. `warm_init` high in cycle d gives `halt_req` = 0 in cycle d+1. Parity strobes that arrive while halted or during the pulse give no further pulse.
- R5: With `checker_en`=1 and `cmp_valid`=1 in cycle c and `own_val` != `pin_val`, `err_out` is 0 in cycle c+1 and 1 in cycle c+2. Back-to-back mismatches give back-to-back high cycles.
- R6: If `checker_en`=0, or `cmp_valid`=0, or `own_val` == `pin_val`, the compare in that cycle has no effect on `err_out`.
- R7: When a parity pulse and a mismatch report fall due in the same or adjacent cycles, `err_out` is their OR.
- R8: Mismatch reporting keeps working while `halt_req` is 1.
- R9: `warm_init` high in cycle c or c+1 cancels a mismatch detected in cycle c, so `err_out` stays 0 in cycle c+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warm_init | input | 1 | Synchronous warm initialization; clears halt and any pending mismatch |
| par_err | input | N_SRC | Parity-error strobes from arrays |
| checker_en | input | 1 | 1 = device strapped as lockstep checker |
| cmp_valid | input | 1 | Marks own and pin values as meaningful this cycle |
| own_val | input | W | Values computed by this device |
| pin_val | input | W | Values observed on the shared pins |
| err_out | output | 1 | Error report |
| halt_req | output | 1 | Sticky halt request |

## Verification
A parity strobe is due on `err_out` one cycle later and on `halt_req` two cycles later. A mismatch is due on `err_out` exactly two cycles later and must be absent one cycle later. Clearing by `warm_init` shows on the next cycle. The bench drives every stimulus just after a falling edge and samples each output at the falling edge that ends the cycle in which its result is due. It checks the cycle before the due cycle as well, so a result that arrives early or late is caught. The compare sweep covers every value of `checker_en`, `cmp_valid`, `own_val` and `pin_val` for a 4-bit compare. Each compare vector is followed by idle cycles, so no two expectations overlap.

// File: rtl/fault_pkg.sv
package fault_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PULSE = 2'd1,
        ST_HALT  = 2'd2
    } par_state_e;

    localparam int REPORT_LAG = 2;

endpackage

// File: rtl/par_fsm.sv
module par_fsm
    import fault_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_init,
    input  logic [N_SRC-1:0] par_err,
    output logic             pulse,
    output logic             halted
);

    par_state_e state_q;
    par_state_e state_d;
    logic       hit;

    assign hit = |par_err;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (warm_init) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:   state_d = hit ? ST_PULSE : ST_RUN;
                ST_PULSE: state_d = ST_HALT;
                ST_HALT:  state_d = ST_HALT;
                default:  state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        pulse  = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_PULSE: pulse  = 1'b1;
            ST_HALT:  halted = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/redund_cmp.sv
module redund_cmp #(
    parameter int W = 16
) (
    input  logic         checker_en,
    input  logic         cmp_valid,
    input  logic [W-1:0] own_val,
    input  logic [W-1:0] pin_val,
    output logic         mismatch
);

    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = own_val[i] ^ pin_val[i];
    end

    assign mismatch = checker_en & cmp_valid & (|diff);

endmodule

// File: rtl/redund_pipe.sv
module redund_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic din,
    output logic dout
);

    logic [DEPTH:0] tap;

    assign tap[0] = din;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap[s+1] <= 1'b0;
            end else if (flush) begin
                tap[s+1] <= 1'b0;
            end else begin
                tap[s+1] <= tap[s];
            end
        end
    end

    assign dout = tap[DEPTH];

endmodule

// File: rtl/fault_reporter.sv
module fault_reporter
    import fault_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_init,
    input  logic [N_SRC-1:0] par_err,
    input  logic             checker_en,
    input  logic             cmp_valid,
    input  logic [W-1:0]     own_val,
    input  logic [W-1:0]     pin_val,
    output logic             err_out,
    output logic             halt_req
);

    logic par_pulse;
    logic mis_now;
    logic mis_late;

    par_fsm #(.N_SRC(N_SRC)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_init (warm_init),
        .par_err   (par_err),
        .pulse     (par_pulse),
        .halted    (halt_req)
    );

    redund_cmp #(.W(W)) u_cmp (
        .checker_en (checker_en),
        .cmp_valid  (cmp_valid),
        .own_val    (own_val),
        .pin_val    (pin_val),
        .mismatch   (mis_now)
    );

    redund_pipe #(.DEPTH(REPORT_LAG)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (warm_init),
        .din   (mis_now),
        .dout  (mis_late)
    );

    assign err_out = par_pulse | mis_late;

endmodule

// File: rtl/fault_reporter_chk.sv
module fault_reporter_chk #(
    parameter int N_SRC = 4,
    parameter int W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             warm_init,
    input logic [N_SRC-1:0] par_err,
    input logic             checker_en,
    input logic             cmp_valid,
    input logic [W-1:0]     own_val,
    input logic [W-1:0]     pin_val,
    input logic             err_out,
    input logic             halt_req
);

    logic det;
    assign det = checker_en && cmp_valid && (own_val != pin_val);

    // R3: halt only starts right after an error pulse
    p_halt_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(err_out));

    // R4: halt is sticky until warm init
    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !warm_init) |=> halt_req);

    // R4: warm init clears halt
    p_init_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        warm_init |=> !halt_req);

    // R5: detected mismatch is reported two clocks later
    p_mis_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(det, 2) && $past(rst_n, 2) && $past(rst_n, 1)
         && !$past(warm_init, 2) && !$past(warm_init, 1)) |-> err_out);

    // R6: every error report has a cause
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> ($past(|par_err) || $past(det, 2)));

endmodule

bind fault_reporter fault_reporter_chk #(.N_SRC(N_SRC), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_init  (warm_init),
    .par_err    (par_err),
    .checker_en (checker_en),
    .cmp_valid  (cmp_valid),
    .own_val    (own_val),
    .pin_val    (pin_val),
    .err_out    (err_out),
    .halt_req   (halt_req)
);

// File: tb/fault_reporter_tb.sv
module fault_reporter_tb;

    localparam int NS = 3;
    localparam int WB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warm_init = 1'b0;
    logic [NS-1:0] par_err = '0;
    logic          checker_en = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [WB-1:0] own_val = '0;
    logic [WB-1:0] pin_val = '0;
    logic          err_out;
    logic          halt_req;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fault_reporter #(.N_SRC(NS), .W(WB)) u_dut (
        .clk(clk), .rst_n(rst_n), .warm_init(warm_init), .par_err(par_err),
        .checker_en(checker_en), .cmp_valid(cmp_valid), .own_val(own_val),
        .pin_val(pin_val), .err_out(err_out), .halt_req(halt_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_init();
        warm_init = 1'b1;
        step();
        warm_init = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        step();
        chk("R1 err in reset", err_out, 1'b0);
        chk("R1 halt in reset", halt_req, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 err after reset", err_out, 1'b0);
        chk("R1 halt after reset", halt_req, 1'b0);

        // parity sweep, strobe held three cycles
        for (int p = 0; p < (1 << NS); p++) begin
            par_err = NS'(p);
            step();
            chk("R2 pulse", err_out, p != 0);
            chk("R3 no halt yet", halt_req, 1'b0);
            step();
            chk("R2 pulse ends", err_out, 1'b0);
            chk("R3 halt set", halt_req, p != 0);
            step();
            chk("R4 no repulse while halted", err_out, 1'b0);
            par_err = '0;
            step();
            chk("R4 halt sticky", halt_req, p != 0);
            do_init();
            chk("R4 init clears halt", halt_req, 1'b0);
            chk("R4 err quiet after init", err_out, 1'b0);
        end

        // exhaustive compare sweep
        for (int v = 0; v < 1024; v++) begin
            logic e;
            checker_en = v[9];
            cmp_valid  = v[8];
            own_val    = v[7:4];
            pin_val    = v[3:0];
            e = v[9] && v[8] && (v[7:4] != v[3:0]);
            step();
            checker_en = 1'b0; cmp_valid = 1'b0;
            chk("R5 not early", err_out, 1'b0);
            step();
            chk(e ? "R5 mismatch lag" : "R6 ignored compare", err_out, e);
            step();
            chk("R5 one cycle", err_out, 1'b0);
        end

        // R5 back-to-back mismatches
        checker_en = 1'b1; cmp_valid = 1'b1; own_val = 4'h3; pin_val = 4'h2;
        step();
        chk("R5 b2b c+1", err_out, 1'b0);
        step();
        cmp_valid = 1'b0;
        chk("R5 b2b first", err_out, 1'b1);
        step();
        chk("R5 b2b second", err_out, 1'b1);
        step();
        chk("R5 b2b end", err_out, 1'b0);

        // R7 parity and mismatch in the same cycle
        par_err = 3'b010; cmp_valid = 1'b1;
        step();
        par_err = '0; cmp_valid = 1'b0;
        chk("R7 parity part", err_out, 1'b1);
        step();
        chk("R7 mismatch part", err_out, 1'b1);
        chk("R7 halt", halt_req, 1'b1);
        step();
        chk("R7 quiet", err_out, 1'b0);

        // R8 mismatch while halted
        cmp_valid = 1'b1;
        step();
        cmp_valid = 1'b0;
        step();
        chk("R8 report while halted", err_out, 1'b1);
        chk("R8 still halted", halt_req, 1'b1);
        step();

        // R9 init cancels pending mismatch (init in c+1)
        cmp_valid = 1'b1;
        step();
        cmp_valid = 1'b0;
        warm_init = 1'b1;
        step();
        warm_init = 1'b0;
        chk("R9 cancelled", err_out, 1'b0);
        chk("R4 halt cleared", halt_req, 1'b0);
        step();
        chk("R9 stays quiet", err_out, 1'b0);

        // R9 init in the detection cycle
        cmp_valid = 1'b1; warm_init = 1'b1;
        step();
        cmp_valid = 1'b0; warm_init = 1'b0;
        step();
        chk("R9 init same cycle", err_out, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule